// File: doc/BRIEF.md
# Receive CRC Checker

This block checks the frame check sequence on the receive side of a synchronous serial receiver. Deserialised data arrives one bit per cycle with a valid strobe. The block folds each accepted bit into a 16-bit CRC register using the CCITT polynomial x^16 + x^12 + x^5 + 1. It shows the running remainder and a CRC-good flag, which the receiver samples at the end of a frame.

The register returns to its mode-dependent preset on a number of events. A software command written into a 2-bit field does it in both modes, and so does turning the receiver off. In bit-oriented (SDLC) mode, being in hunt and seeing a flag also do it. In plain synchronous mode nothing resets the checker between messages, except entry into hunt or an explicit software command. Flag and sync detection, zero-bit deletion, FIFOs and the processor bus are outside the block, and their results reach it only as strobes.

Top module: `rx_crc_check`

## Requirements
- R1: While rst_ni is low and after it is released, rem_o is 0x0000. With mode_sdlc_i = 0, crc_ok_o is then 1.
- R2: An accepted bit updates the register in the cycle after it is presented. A bit is accepted when rx_en_i = 1, bit_vld_i = 1 and no initialise event occurs. The update takes the register MSB-first: fb = rem[15] ^ bit_i, then rem = (rem << 1) ^ (fb ? 0x1021 : 0).
- R3: A write with cmd_we_i = 1 and cmd_i = 2'b01 loads the preset in the next cycle. The preset is 0xFFFF when mode_sdlc_i = 1 and 0x0000 when mode_sdlc_i = 0.
- R4: A write with cmd_i equal to 2'b00, 2'b10 or 2'b11 leaves rem_o unchanged.
- R5: While rx_en_i = 0, the register is reloaded with the preset of the current mode on every cycle, and bits are ignored.
- R6: With mode_sdlc_i = 1, every cycle in which hunt_i = 1 loads the preset 0xFFFF.
- R7: With mode_sdlc_i = 1, a cycle with flag_i = 1 loads the preset 0xFFFF.
- R8: With mode_sdlc_i = 0, flag_i has no effect. Only the first cycle of hunt_i = 1 after hunt_i = 0 loads the preset. Later cycles with hunt_i held high accumulate bits normally.
- R9: A cycle with bit_vld_i = 0 and no initialise event leaves rem_o unchanged.
- R10: When an initialise event and an accepted data bit fall in the same cycle, the preset is loaded and the bit is discarded.
- R11: crc_ok_o is combinational from rem_o and mode_sdlc_i. It is 1 when rem_o equals 0x1D0F in SDLC mode, or 0x0000 in synchronous mode, and 0 otherwise.
- R12: Two complete frames end with crc_ok_o = 1:
  - an SDLC frame followed by its complemented CRC sent MSB-first;
  - a synchronous frame followed by its true CRC sent MSB-first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_sdlc_i | input | 1 | 1 = bit-oriented SDLC, 0 = plain synchronous |
| rx_en_i | input | 1 | Receiver enable |
| hunt_i | input | 1 | Receiver is in hunt |
| flag_i | input | 1 | Flag-received pulse |
| cmd_we_i | input | 1 | Write strobe for the CRC command field |
| cmd_i | input | 2 | CRC command code, where 01 means initialise the checker |
| bit_vld_i | input | 1 | Received data bit is valid |
| bit_i | input | 1 | Received data bit |
| rem_o | output | 16 | Current CRC remainder |
| crc_ok_o | output | 1 | Remainder equals the good residue for the mode |

## Verification
A reference model compares rem_o and crc_ok_o against its own CRC on every clock. The bench concentrates on cases where the two modes differ.

- Hunt held high in synchronous mode: a design that used the level instead of the entry edge would keep the remainder frozen at zero.
- Flag pulses in synchronous mode: a design that took them would wipe a message's CRC in the middle of the message.
- A flag or command that arrives together with a valid bit: a design that let the data win would be left one bit off the preset.
- The non-initialising command codes: a design that decoded only one bit of the field would clear the register on 2'b11.
- A turn-off or a mode change: loading the wrong preset would cause a frame that is good in the other mode to miss its residue.

// File: rtl/rx_crc_pkg.sv
package rx_crc_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CCITT_POLY   = 16'h1021;
  localparam logic [CRC_W-1:0] PRESET_BITOR = 16'hFFFF;
  localparam logic [CRC_W-1:0] PRESET_SYNC  = 16'h0000;
  localparam logic [CRC_W-1:0] GOOD_BITOR   = 16'h1D0F;
  localparam logic [CRC_W-1:0] GOOD_SYNC    = 16'h0000;

  typedef enum logic [1:0] {
    CMD_NOP      = 2'b00,
    CMD_RX_INIT  = 2'b01,
    CMD_TX_INIT  = 2'b10,
    CMD_EOM_CLR  = 2'b11
  } crc_cmd_e;
endpackage

// File: rtl/rx_crc_init_ctl.sv
module rx_crc_init_ctl
  import rx_crc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_sdlc_i,
  input  logic       rx_en_i,
  input  logic       hunt_i,
  input  logic       flag_i,
  input  logic       cmd_we_i,
  input  logic [1:0] cmd_i,
  output logic       init_o
);
  logic hunt_q;
  logic cmd_init, hunt_entry, bitor_auto, sync_auto;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hunt_q <= 1'b0;
    else         hunt_q <= hunt_i;
  end

  assign cmd_init   = cmd_we_i && (crc_cmd_e'(cmd_i) == CMD_RX_INIT);
  assign hunt_entry = hunt_i && !hunt_q;
  // bit-oriented mode: hunt level and every flag re-arm the checker
  assign bitor_auto = mode_sdlc_i && (hunt_i || flag_i);
  // plain sync: only entry into hunt separates messages
  assign sync_auto  = !mode_sdlc_i && hunt_entry;

  assign init_o = cmd_init || !rx_en_i || bitor_auto || sync_auto;
endmodule

// File: rtl/rx_crc_lfsr.sv
module rx_crc_lfsr #(
  parameter int unsigned         W        = 16,
  parameter logic [W-1:0]        POLY     = 16'h1021,
  parameter logic [W-1:0]        PRE_BIT  = 16'hFFFF,
  parameter logic [W-1:0]        PRE_SYNC = 16'h0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_sdlc_i,
  input  logic         init_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q, rem_nxt, preset;
  logic         fb;

  assign preset = mode_sdlc_i ? PRE_BIT : PRE_SYNC;
  assign fb     = rem_q[W-1] ^ bit_i;

  assign rem_nxt[0] = fb & POLY[0];
  for (genvar i = 1; i < W; i++) begin : g_tap
    assign rem_nxt[i] = rem_q[i-1] ^ (fb & POLY[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (init_i)  rem_q <= preset;   // init wins over data
    else if (shift_i) rem_q <= rem_nxt;
  end

  assign rem_o = rem_q;
endmodule

// File: rtl/rx_crc_match.sv
module rx_crc_match #(
  parameter int unsigned  W        = 16,
  parameter logic [W-1:0] RES_BIT  = 16'h1D0F,
  parameter logic [W-1:0] RES_SYNC = 16'h0000
) (
  input  logic         mode_sdlc_i,
  input  logic [W-1:0] rem_i,
  output logic         ok_o
);
  assign ok_o = (rem_i == (mode_sdlc_i ? RES_BIT : RES_SYNC));
endmodule

// File: rtl/rx_crc_check.sv
module rx_crc_check
  import rx_crc_pkg::*;
#(
  parameter int unsigned  W        = CRC_W,
  parameter logic [W-1:0] POLY     = CCITT_POLY,
  parameter logic [W-1:0] PRE_BIT  = PRESET_BITOR,
  parameter logic [W-1:0] PRE_SYNC = PRESET_SYNC,
  parameter logic [W-1:0] RES_BIT  = GOOD_BITOR,
  parameter logic [W-1:0] RES_SYNC = GOOD_SYNC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_sdlc_i,
  input  logic         rx_en_i,
  input  logic         hunt_i,
  input  logic         flag_i,
  input  logic         cmd_we_i,
  input  logic [1:0]   cmd_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  output logic [W-1:0] rem_o,
  output logic         crc_ok_o
);
  logic init;

  rx_crc_init_ctl u_init (
    .clk_i, .rst_ni, .mode_sdlc_i, .rx_en_i, .hunt_i, .flag_i,
    .cmd_we_i, .cmd_i, .init_o(init)
  );

  rx_crc_lfsr #(.W(W), .POLY(POLY), .PRE_BIT(PRE_BIT), .PRE_SYNC(PRE_SYNC)) u_lfsr (
    .clk_i, .rst_ni, .mode_sdlc_i, .init_i(init),
    .shift_i(bit_vld_i), .bit_i, .rem_o
  );

  rx_crc_match #(.W(W), .RES_BIT(RES_BIT), .RES_SYNC(RES_SYNC)) u_match (
    .mode_sdlc_i, .rem_i(rem_o), .ok_o(crc_ok_o)
  );
endmodule

// File: rtl/rx_crc_check_chk.sv
module rx_crc_check_chk #(
  parameter int unsigned  W        = 16,
  parameter logic [W-1:0] PRE_BIT  = 16'hFFFF,
  parameter logic [W-1:0] PRE_SYNC = 16'h0000
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode_sdlc_i,
  input logic         rx_en_i,
  input logic         hunt_i,
  input logic         flag_i,
  input logic         cmd_we_i,
  input logic [1:0]   cmd_i,
  input logic         bit_vld_i,
  input logic [W-1:0] rem_o
);
  // R3
  cmd_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i == 2'b01) |=> rem_o == ($past(mode_sdlc_i) ? PRE_BIT : PRE_SYNC));
  // R5
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> rem_o == ($past(mode_sdlc_i) ? PRE_BIT : PRE_SYNC));
  // R6
  bitor_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sdlc_i && hunt_i) |=> rem_o == PRE_BIT);
  // R7
  bitor_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sdlc_i && flag_i) |=> rem_o == PRE_BIT);
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && !bit_vld_i && !cmd_we_i && !hunt_i && !flag_i) |=> $stable(rem_o));
  // R1
  always_comb begin
    if (!rst_ni) rst_val_chk: assert (rem_o == '0);
  end
endmodule

bind rx_crc_check rx_crc_check_chk #(.W(W), .PRE_BIT(PRE_BIT), .PRE_SYNC(PRE_SYNC)) u_chk (
  .clk_i, .rst_ni, .mode_sdlc_i, .rx_en_i, .hunt_i, .flag_i,
  .cmd_we_i, .cmd_i, .bit_vld_i, .rem_o
);

// File: tb/rx_crc_check_tb_top.sv
module rx_crc_check_tb_top;
  logic clk = 0, rst_n = 0;
  logic mode = 0, rx_en = 0, hunt = 0, flag = 0, cmd_we = 0, vld = 0, b = 0;
  logic [1:0] cmd = 2'b00;
  logic [15:0] rem;
  logic ok;
  int checks = 0, errors = 0;
  string cur_req = "R2";
  logic [15:0] m_rem;
  logic m_hprev;

  always #4 clk = ~clk;

  rx_crc_check dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_sdlc_i(mode), .rx_en_i(rx_en),
    .hunt_i(hunt), .flag_i(flag), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .bit_vld_i(vld), .bit_i(b), .rem_o(rem), .crc_ok_o(ok)
  );

  function automatic logic [15:0] crc_bit(logic [15:0] r, logic d);
    int x = r;
    int f = ((x >> 15) & 1) ^ int'(d);
    x = (x << 1) & 'hFFFF;
    if (f != 0) x = x ^ 'h1021;
    return 16'(x);
  endfunction

  function automatic logic m_init();
    return (cmd_we && cmd == 2'b01) || !rx_en || (mode && (hunt || flag)) ||
           (!mode && hunt && !m_hprev);
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem <= 16'h0000; m_hprev <= 1'b0;
    end else begin
      if (m_init())  m_rem <= mode ? 16'hFFFF : 16'h0000;
      else if (vld)  m_rem <= crc_bit(m_rem, b);
      m_hprev <= hunt;
    end
  end

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s got %h exp %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic v, logic d);
    logic exp_ok;
    vld = v; b = d;
    @(posedge clk); @(negedge clk);
    exp_ok = mode ? (m_rem == 16'h1D0F) : (m_rem == 16'h0000);
    chk(cur_req, "rem", rem, m_rem);
    chk("R11", "crc_ok", {15'd0, ok}, {15'd0, exp_ok});
    vld = 0; flag = 0; cmd_we = 0; cmd = 2'b00;
  endtask

  task automatic send_byte(logic [7:0] x);
    for (int i = 7; i >= 0; i--) cyc(1'b1, x[i]);
  endtask

  task automatic send_word(logic [15:0] x);
    for (int i = 15; i >= 0; i--) cyc(1'b1, x[i]);
  endtask

  logic [15:0] snap, fcs;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "rem in reset", rem, 16'h0000);
    chk("R1", "ok in reset", {15'd0, ok}, 16'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rem after reset", rem, 16'h0000);

    // R5: receiver off holds preset, bits ignored
    cur_req = "R5";
    rx_en = 0;
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1);
    chk("R5", "off sync preset", rem, 16'h0000);
    mode = 1; cyc(1'b1, 1'b0);
    chk("R5", "off bitor preset", rem, 16'hFFFF);

    // R7 / R2 / R12: SDLC frame
    rx_en = 1; cur_req = "R7";
    flag = 1; cyc(1'b0, 1'b0);
    chk("R7", "flag preset", rem, 16'hFFFF);
    cur_req = "R2";
    send_byte(8'h12); send_byte(8'h34); send_byte(8'hA5);
    chk("R2", "accum", rem, m_rem);
    fcs = m_rem;
    send_word(~fcs);
    chk("R12", "bitor residue", rem, 16'h1D0F);
    chk("R12", "bitor ok", {15'd0, ok}, 16'd1);

    // R10: flag with data bit
    cur_req = "R10";
    send_byte(8'h5C);
    flag = 1; cyc(1'b1, 1'b1);
    chk("R10", "init beats data", rem, 16'hFFFF);

    // R6: hunt level in SDLC
    cur_req = "R6";
    send_byte(8'h3C);
    hunt = 1;
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1);
    chk("R6", "hunt holds preset", rem, 16'hFFFF);
    hunt = 0;

    // R4: other command codes
    cur_req = "R4";
    send_byte(8'hE7);
    snap = rem;
    cmd_we = 1; cmd = 2'b00; cyc(1'b0, 1'b0);
    cmd_we = 1; cmd = 2'b10; cyc(1'b0, 1'b0);
    cmd_we = 1; cmd = 2'b11; cyc(1'b0, 1'b0);
    chk("R4", "non-init codes", rem, snap);

    // R9: no valid bit holds
    cur_req = "R9";
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1);
    chk("R9", "hold", rem, snap);

    // R3: command init in both modes
    cur_req = "R3";
    cmd_we = 1; cmd = 2'b01; cyc(1'b1, 1'b1);
    chk("R3", "bitor cmd preset", rem, 16'hFFFF);
    mode = 0; send_byte(8'h81);
    cmd_we = 1; cmd = 2'b01; cyc(1'b0, 1'b0);
    chk("R3", "sync cmd preset", rem, 16'h0000);

    // R8: sync mode ignores flag; hunt acts on entry only
    cur_req = "R8";
    send_byte(8'hC3);
    snap = rem;
    flag = 1; cyc(1'b0, 1'b0);
    chk("R8", "flag ignored", rem, snap);
    hunt = 1; cyc(1'b1, 1'b1);
    chk("R8", "hunt entry preset", rem, 16'h0000);
    cyc(1'b1, 1'b1);
    chk("R8", "held hunt accumulates", rem, 16'h1021);
    hunt = 0;

    // R12 sync frame, R11 negative
    cur_req = "R12";
    cmd_we = 1; cmd = 2'b01; cyc(1'b0, 1'b0);
    send_byte(8'hDE); send_byte(8'hAD);
    chk("R11", "ok low mid-frame", {15'd0, ok}, {15'd0, rem == 16'h0000});
    fcs = m_rem;
    send_word(fcs);
    chk("R12", "sync residue", rem, 16'h0000);
    chk("R12", "sync ok", {15'd0, ok}, 16'd1);
    mode = 1; cyc(1'b0, 1'b0);
    chk("R11", "zero not good in bitor", {15'd0, ok}, 16'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule